// File: doc/BRIEF.md
# Coherence Tree Lookup Stage for a Mesh Router

This block is the coherence stage of one router in a two-dimensional mesh. It holds a small direct-mapped tree cache, indexed by line address. For each cached line it notes which of the four mesh links belong to that line's sharing tree. Each link is marked as leading toward the root (the home side) or away from it (the sharer side). The entry also notes whether the local tile holds a copy.

Each cycle the stage takes at most one coherence message, tagged with its arrival port, and looks its line up in the tree cache. One cycle later it emits the message kind and a set of output ports:

- A request that meets a tree is steered toward a sharer instead of the home node.
- A read reply grows the tree as it passes through.
- A write floods invalidations along the tree. Acknowledgements are gathered hop by hop, and the write reply is released once all have been gathered.
- Anything that misses the cache is routed in dimension order, X first and then Y.

Top module: `rc_tree_stage`

## Requirements
- R1: After reset there is no output, in_ready is 1, and every line misses the tree cache.
- R2: A request that misses is routed toward its home node with one cycle of latency. The home node is X = addr[7:6] and Y = addr[5:4]. If home X is greater than the router's X the message goes east, if smaller it goes west. Otherwise, if home Y is greater it goes north, if smaller south, and if equal it goes to local. The port mask bits are N=bit0, S=bit1, E=bit2, W=bit3, local=bit4, and port numbers use the same values 0..4.
- R3: A read reply (kind 1) is routed toward the requester coordinates (src_x, src_y) by the same X-then-Y rule. At the same time it marks its arrival link as toward-root, unless it arrived from local. It marks its output link as away-from-root, or sets the local-copy flag if it leaves to local.
- R4: A read request (kind 0) that hits goes to local if the local-copy flag is set. Otherwise it goes to the lowest-numbered away-from-root link other than its arrival port. If there is no such link it falls back to the R2 route.
- R5: A write request (kind 2) that hits, with tree links other than its arrival port, sends an invalidation (kind 4) on all those links. It marks the line busy and clears the local copy.
- R6: While a line is busy, a read or write request to it drives in_ready low, produces no output and changes nothing.
- R7: An acknowledgement (kind 5) from a pending link clears that link from the pending set. When the last pending link is cleared, the stage sends one message back through the port the invalidation or write arrived on and empties the entry. That message is an acknowledgement if the entry was reached by an invalidation, or a write reply (kind 3) if it was reached by a write request. Acknowledgements that leave links still pending produce no output.
- R8: An invalidation that reaches a line with no tree links other than its arrival port, or that misses, is answered next cycle by an acknowledgement through the arrival port. A hit entry is emptied.
- R9: A write request that hits a line with no tree links other than its arrival port is answered next cycle by a write reply through the arrival port, and the entry is emptied.
- R10: Replies, invalidations and acknowledgements are never held back, even when they address a busy line.
- R11: The line index is addr[1:0] and the tag is addr[7:2]. A read reply whose tag differs from a non-busy entry replaces that entry. If the entry is busy, the reply is forwarded and the entry is left untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming message present |
| in_kind | input | 3 | Message kind (0 read req, 1 read reply, 2 write req, 3 write reply, 4 invalidate, 5 ack) |
| in_port | input | 3 | Arrival port number (0 N, 1 S, 2 E, 3 W, 4 local) |
| in_addr | input | 8 | Line address |
| in_src_x | input | 2 | Requester X coordinate, used by replies |
| in_src_y | input | 2 | Requester Y coordinate, used by replies |
| in_ready | output | 1 | Low when a request is held back by a busy line |
| out_valid | output | 1 | Outgoing message present |
| out_kind | output | 3 | Outgoing message kind |
| out_ports | output | 5 | Chosen output port set |
| out_addr | output | 8 | Outgoing line address |
| out_src_x | output | 2 | Requester X carried along |
| out_src_y | output | 2 | Requester Y carried along |

## Verification
The final acknowledgement of a write does two things at one clock edge: it emits the completion message and it frees the line that was blocking requests. The bench provokes this by presenting a read request to the same line in the cycle directly after that acknowledgement. It expects in_ready to be high and the request to leave by the miss route toward home, rather than being stalled or steered into the torn-down tree. The reverse collision is also checked. A read reply arrives for a busy index while invalidations are still outstanding. It must be forwarded at once, and the later acknowledgements must still complete the original write as if the reply had never passed.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [2:0] {
    K_RD_REQ = 3'd0,
    K_RD_REP = 3'd1,
    K_WR_REQ = 3'd2,
    K_WR_REP = 3'd3,
    K_INV    = 3'd4,
    K_ACK    = 3'd5
  } kind_e;

  localparam int NPORT = 5;
  localparam int P_LOC = 4;
endpackage

// File: rtl/rc_dor_route.sv
module rc_dor_route #(
  parameter int CW = 2
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  output logic [4:0]    dir_mask
);
  always_comb begin
    if (dst_x > cur_x)      dir_mask = 5'b00100;
    else if (dst_x < cur_x) dir_mask = 5'b01000;
    else if (dst_y > cur_y) dir_mask = 5'b00001;
    else if (dst_y < cur_y) dir_mask = 5'b00010;
    else                    dir_mask = 5'b10000;
  end
endmodule

// File: rtl/rc_tree_store.sv
module rc_tree_store #(
  parameter int DEPTH = 4,
  parameter int ENT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [ENT_W-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [ENT_W-1:0]         rd_data
);
  localparam int IW = $clog2(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] row_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row_en
    assign row_en[g] = wr_en && (wr_idx == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (row_en[i]) mem[i] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/rc_tree_stage.sv
module rc_tree_stage
  import rc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CW     = 2,
  parameter int DEPTH  = 4,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_kind,
  input  logic [2:0]        in_port,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CW-1:0]     in_src_x,
  input  logic [CW-1:0]     in_src_y,
  output logic              in_ready,
  output logic              out_valid,
  output logic [2:0]        out_kind,
  output logic [4:0]        out_ports,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CW-1:0]     out_src_x,
  output logic [CW-1:0]     out_src_y
);
  localparam int IW    = $clog2(DEPTH);
  localparam int TAG_W = ADDR_W - IW;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic [3:0]       to_rt;
    logic [3:0]       from_rt;
    logic             dat;
    logic             busy;
    logic             outst;
    logic [3:0]       pend;
    logic [2:0]       back;
  } ent_t;
  localparam int ENT_W = $bits(ent_t);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [IW-1:0]    idx;
  logic [TAG_W-1:0] tag;
  logic [ENT_W-1:0] rd_raw;
  ent_t             ent;
  ent_t             went;
  logic             we;
  logic             hit;
  logic             is_req;
  logic             stall;
  logic [3:0]       in_bit4;
  logic [4:0]       in_bit5;
  logic [4:0]       route_home;
  logic [4:0]       route_src;
  logic [3:0]       others;
  logic [3:0]       br;
  logic [3:0]       rem;
  logic             nx_vld;
  logic [2:0]       nx_kind;
  logic [4:0]       nx_ports;

  assign idx = in_addr[IW-1:0];
  assign tag = in_addr[ADDR_W-1:IW];
  assign ent = ent_t'(rd_raw);

  rc_tree_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_en  (we),
    .wr_idx (idx),
    .wr_data(went),
    .rd_idx (idx),
    .rd_data(rd_raw)
  );

  rc_dor_route #(.CW(CW)) u_route_home (
    .cur_x   (CW'(MY_X)),
    .cur_y   (CW'(MY_Y)),
    .dst_x   (in_addr[ADDR_W-1 -: CW]),
    .dst_y   (in_addr[ADDR_W-1-CW -: CW]),
    .dir_mask(route_home)
  );

  rc_dor_route #(.CW(CW)) u_route_src (
    .cur_x   (CW'(MY_X)),
    .cur_y   (CW'(MY_Y)),
    .dst_x   (in_src_x),
    .dst_y   (in_src_y),
    .dir_mask(route_src)
  );

  assign hit     = ent.vld && (ent.tag == tag);
  assign is_req  = (in_kind == K_RD_REQ) || (in_kind == K_WR_REQ);
  assign stall   = in_valid && is_req && hit && ent.busy;
  assign in_ready = !stall;
  assign in_bit5 = 5'b00001 << in_port;
  assign in_bit4 = in_bit5[3:0];
  assign others  = ent.from_rt & ~in_bit4;
  assign br      = (ent.to_rt | ent.from_rt) & ~in_bit4;
  assign rem     = ent.pend & ~in_bit4;

  // next-state: decision and tree update
  always_comb begin
    nx_vld   = 1'b0;
    nx_kind  = in_kind;
    nx_ports = '0;
    we       = 1'b0;
    went     = ent;
    if (in_valid && !stall) begin
      nx_vld = 1'b1;
      case (in_kind)
        K_RD_REQ: begin
          if (hit && ent.dat)  nx_ports = 5'b10000;
          else if (hit && |others) nx_ports = {1'b0, others & (~others + 4'd1)};
          else                 nx_ports = route_home;
        end
        K_WR_REQ, K_INV: begin
          if (hit) begin
            we = 1'b1;
            if (br == 4'd0) begin
              nx_kind  = (in_kind == K_WR_REQ) ? K_WR_REP : K_ACK;
              nx_ports = in_bit5;
              went     = '0;
            end else begin
              nx_kind    = K_INV;
              nx_ports   = {1'b0, br};
              went.busy  = 1'b1;
              went.outst = (in_kind == K_WR_REQ);
              went.pend  = br;
              went.back  = in_port;
              went.dat   = 1'b0;
            end
          end else if (in_kind == K_INV) begin
            nx_kind  = K_ACK;
            nx_ports = in_bit5;
          end else begin
            nx_ports = route_home;
          end
        end
        K_ACK: begin
          if (hit && ent.busy && |(ent.pend & in_bit4)) begin
            we = 1'b1;
            if (rem == 4'd0) begin
              nx_kind  = ent.outst ? K_WR_REP : K_ACK;
              nx_ports = 5'b00001 << ent.back;
              went     = '0;
            end else begin
              nx_vld    = 1'b0;
              went.pend = rem;
            end
          end else begin
            nx_vld = 1'b0;
          end
        end
        K_RD_REP, K_WR_REP: begin
          nx_ports = route_src;
          if (in_kind == K_RD_REP && !(!hit && ent.vld && ent.busy)) begin
            we = 1'b1;
            if (!hit) went = '0;
            went.vld   = 1'b1;
            went.tag   = tag;
            went.to_rt = went.to_rt | in_bit4;
            if (route_src[4]) went.dat = 1'b1;
            else              went.from_rt = went.from_rt | route_src[3:0];
          end
        end
        default: nx_vld = 1'b0;
      endcase
    end
  end

  // output register
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_ports <= '0;
      out_addr  <= '0;
      out_src_x <= '0;
      out_src_y <= '0;
    end else begin
      out_valid <= nx_vld;
      if (nx_vld) begin
        out_kind  <= nx_kind;
        out_ports <= nx_ports;
        out_addr  <= in_addr;
        out_src_x <= in_src_x;
        out_src_y <= in_src_y;
      end
    end
  end
endmodule

// File: rtl/rc_tree_stage_chk.sv
module rc_tree_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [2:0] in_kind,
  input logic [2:0] in_port,
  input logic       in_ready,
  input logic       out_valid,
  input logic [2:0] out_kind,
  input logic [4:0] out_ports
);
  // R6: a held-back request leaves no output behind
  a_r6_stall_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !out_valid);

  // R7, R8: single-destination kinds leave on exactly one port
  a_r7_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_kind == 3'd5 || out_kind == 3'd3 || out_kind == 3'd1))
      |-> $onehot(out_ports));

  // R2: every emitted message has somewhere to go
  a_r2_out_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ports != 5'd0));

  // R5: invalidations never return through the arrival port
  a_r5_inv_not_back: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 3'd4) |-> (((out_ports >> $past(in_port)) & 5'd1) == 5'd0));

  // R10: non-request kinds are always accepted
  a_r10_reply_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind != 3'd0 && in_kind != 3'd2) |-> in_ready);
endmodule

bind rc_tree_stage rc_tree_stage_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_kind  (in_kind),
  .in_port  (in_port),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_kind (out_kind),
  .out_ports(out_ports)
);

// File: tb/test_rc_tree_stage.sv
module test_rc_tree_stage;
  import rc_pkg::*;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [2:0] in_kind;
  logic [2:0] in_port;
  logic [7:0] in_addr;
  logic [1:0] in_src_x;
  logic [1:0] in_src_y;
  logic       in_ready;
  logic       out_valid;
  logic [2:0] out_kind;
  logic [4:0] out_ports;
  logic [7:0] out_addr;
  logic [1:0] out_src_x;
  logic [1:0] out_src_y;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [2:0] kind;
    logic [4:0] ports;
    logic [7:0] addr;
    string      req;
  } exp_t;
  exp_t sb[$];

  localparam logic [4:0] MN = 5'b00001, MS = 5'b00010, ME = 5'b00100,
                         MW = 5'b01000, ML = 5'b10000;
  localparam logic [2:0] PN = 3'd0, PS = 3'd1, PE = 3'd2, PW = 3'd3, PL = 3'd4;

  rc_tree_stage i_rc_tree_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_port(in_port), .in_addr(in_addr), .in_src_x(in_src_x), .in_src_y(in_src_y),
    .in_ready(in_ready), .out_valid(out_valid), .out_kind(out_kind),
    .out_ports(out_ports), .out_addr(out_addr), .out_src_x(out_src_x),
    .out_src_y(out_src_y)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // driver: one message per cycle, expectation pushed to the scoreboard
  task automatic send(input logic [2:0] k, input logic [2:0] p, input logic [7:0] a,
                      input logic [1:0] sx, input logic [1:0] sy, input bit expv,
                      input logic [2:0] ek, input logic [4:0] ep, input bit erdy,
                      input string req);
    exp_t e;
    @(negedge clk);
    #1;
    in_valid = 1'b1; in_kind = k; in_port = p; in_addr = a;
    in_src_x = sx; in_src_y = sy;
    #1;
    checks++;
    if (in_ready !== erdy) begin
      fails++;
      $display("FAIL %s: in_ready got %b exp %b", req, in_ready, erdy);
    end
    if (expv) begin
      e.kind = ek; e.ports = ep; e.addr = a; e.req = req;
      sb.push_back(e);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // monitor: compare outputs as they appear
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL unexpected output: kind got %0d ports got %b exp none", out_kind, out_ports);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (out_kind !== e.kind || out_ports !== e.ports || out_addr !== e.addr) begin
          fails++;
          $display("FAIL %s: kind got %0d exp %0d ports got %b exp %b addr got %h exp %h",
                   e.req, out_kind, e.kind, out_ports, e.ports, out_addr, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_kind = '0; in_port = '0; in_addr = '0;
    in_src_x = '0; in_src_y = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: out_valid got %b exp 0, in_ready got %b exp 1", out_valid, in_ready);
    end

    // R2: miss routing in dimension order from router (1,1)
    send(K_RD_REQ, PL, 8'hD0, 0, 0, 1, K_RD_REQ, ME, 1, "R2 east");
    send(K_RD_REQ, PL, 8'h10, 0, 0, 1, K_RD_REQ, MW, 1, "R2 west");
    send(K_RD_REQ, PL, 8'h70, 0, 0, 1, K_RD_REQ, MN, 1, "R2 north");
    send(K_RD_REQ, PL, 8'h40, 0, 0, 1, K_RD_REQ, MS, 1, "R2 south");
    send(K_RD_REQ, PL, 8'h50, 0, 0, 1, K_RD_REQ, ML, 1, "R2 local");

    // R3: read reply builds the tree for line 0x01 (root on W, sharer on E)
    send(K_RD_REP, PW, 8'h01, 2, 1, 1, K_RD_REP, ME, 1, "R3 reply east");
    // R4: request meets the tree and is steered east, not west to home
    send(K_RD_REQ, PS, 8'h01, 0, 0, 1, K_RD_REQ, ME, 1, "R4 reroute");
    // R3: reply to local sets the local-copy flag; R4 then serves locally
    send(K_RD_REP, PW, 8'h01, 1, 1, 1, K_RD_REP, ML, 1, "R3 reply local");
    send(K_RD_REQ, PN, 8'h01, 0, 0, 1, K_RD_REQ, ML, 1, "R4 local first");

    // R4: lowest-numbered sharer link (S before W) on line 0x02
    send(K_RD_REP, PE, 8'h02, 0, 1, 1, K_RD_REP, MW, 1, "R3 reply west");
    send(K_RD_REP, PE, 8'h02, 1, 0, 1, K_RD_REP, MS, 1, "R3 reply south");
    send(K_RD_REQ, PL, 8'h02, 0, 0, 1, K_RD_REQ, MS, 1, "R4 lowest link");

    // R5: write from S floods W and E
    send(K_WR_REQ, PS, 8'h01, 0, 0, 1, K_INV, MW | ME, 1, "R5 invalidate");
    // R6: requests to the busy line are held
    send(K_RD_REQ, PN, 8'h01, 0, 0, 0, 0, 0, 0, "R6 read stalled");
    send(K_WR_REQ, PL, 8'h01, 0, 0, 0, 0, 0, 0, "R6 write stalled");
    // R10, R11: reply to busy index with another tag passes untouched
    send(K_RD_REP, PE, 8'hC1, 0, 1, 1, K_RD_REP, MW, 1, "R10 reply on busy");
    // R7: first ack silent, last ack releases write reply toward S
    send(K_ACK, PE, 8'h01, 0, 0, 0, 0, 0, 1, "R7 partial ack");
    send(K_ACK, PW, 8'h01, 0, 0, 1, K_WR_REP, MS, 1, "R7 write reply");
    // entry freed at the same edge: next request misses toward home (0,0)
    send(K_RD_REQ, PL, 8'h01, 0, 0, 1, K_RD_REQ, MW, 1, "R7 freed line");

    // R7: invalidation relay on line 0x02 (root E, sharers S and W)
    send(K_INV, PE, 8'h02, 0, 0, 1, K_INV, MS | MW, 1, "R8 relay invalidate");
    send(K_ACK, PS, 8'h02, 0, 0, 0, 0, 0, 1, "R7 relay partial");
    send(K_ACK, PW, 8'h02, 0, 0, 1, K_ACK, ME, 1, "R7 relay ack up");

    // R8: leaf answers at once, then the miss case answers too
    send(K_RD_REP, PN, 8'h03, 1, 1, 1, K_RD_REP, ML, 1, "R3 leaf build");
    send(K_INV, PN, 8'h03, 0, 0, 1, K_ACK, MN, 1, "R8 leaf ack");
    send(K_INV, PN, 8'h03, 0, 0, 1, K_ACK, MN, 1, "R8 miss ack");

    // R9: write meets a tree with nothing beyond its arrival link
    send(K_RD_REP, PW, 8'h13, 1, 1, 1, K_RD_REP, ML, 1, "R3 build 0x13");
    send(K_WR_REQ, PW, 8'h13, 0, 0, 1, K_WR_REP, MW, 1, "R9 direct reply");

    // R11: replacement of a non-busy entry
    send(K_RD_REP, PW, 8'h21, 2, 1, 1, K_RD_REP, ME, 1, "R3 build 0x21");
    send(K_RD_REQ, PL, 8'h21, 0, 0, 1, K_RD_REQ, ME, 1, "R11 hit before");
    send(K_RD_REP, PN, 8'h31, 2, 1, 1, K_RD_REP, ME, 1, "R11 replacing reply");
    send(K_RD_REQ, PL, 8'h21, 0, 0, 1, K_RD_REQ, MW, 1, "R11 old tag misses");
    send(K_RD_REQ, PL, 8'h31, 0, 0, 1, K_RD_REQ, ME, 1, "R11 new tag hits");

    idle();
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d outputs missing exp 0", sb.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule